// File: doc/BRIEF.md
# Keypad Limit Entry Controller

This block lets an operator enter two limits for a bottle-filling station: how many pills go into each bottle and how many bottles are filled in total. Each limit is two decimal digits. The operator moves a cursor over the four editable digits with left and right button pulses. A decoded keypad digit, arriving with its valid strobe, overwrites the digit under the cursor. A confirm pulse turns the digits into two committed limits, and each limit is clamped to its own ceiling at that moment.

The block drives an eight-slot digit buffer for a display and an eight-bit blink mask that marks the digit under the cursor. Keypad scanning, button debouncing and the display multiplexer are outside the block. It accepts input only while the mode input is low (set mode). While that input is high, it holds everything it shows and everything it has committed.

Top module: `limit_entry_ctrl`

## Requirements
- R1: After a synchronous active-low reset, both committed limits are 0, the four editable digits are 0, the cursor is on slot 0 (blink_mask = 8'h01), and disp_digits reads 32'hAAAA_0000.
- R2: disp_digits slot k occupies bits [4k+3:4k]. Slot 0 is pills ones, slot 1 is pills tens, slot 2 is bottles ones and slot 3 is bottles tens. Slots 4 to 7 always carry the blank code 10.
- R3: blink_mask always has exactly one bit set, at the cursor slot, and that slot is in the range 0 to 3.
- R4: A left pulse moves the cursor from slot n to slot n+1, and from slot 3 it wraps to slot 0. A right pulse moves it from n to n-1, and from slot 0 it wraps to slot 3. Left and right in the same cycle leave the cursor where it is. The new position shows one cycle after the pulse.
- R5: key_valid with a key_digit of 0 to 9 overwrites only the digit under the cursor, as it stands before any move in the same cycle. Key codes 10 to 15 are ignored.
- R6: A confirm pulse sets pill_limit to min(10*tens+ones, 50) and bottle_limit to min(10*tens+ones, 18), both visible one cycle later. The editable digits and the cursor are left unchanged.
- R7: The committed limits change only in the cycle after a confirm pulse.
- R8: While set_mode_n is high, every key, left, right and confirm input is ignored, and all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_mode_n | input | 1 | Low selects set mode; high locks the block |
| key_valid | input | 1 | Single-cycle strobe for key_digit |
| key_digit | input | 4 | Decoded keypad code |
| btn_left | input | 1 | Single-cycle cursor-left pulse |
| btn_right | input | 1 | Single-cycle cursor-right pulse |
| btn_confirm | input | 1 | Single-cycle confirm pulse |
| pill_limit | output | 7 | Committed pills per bottle |
| bottle_limit | output | 7 | Committed bottle count |
| disp_digits | output | 32 | Eight 4-bit display codes, slot 0 in the low nibble |
| blink_mask | output | 8 | One-hot marker of the edited slot |

## Verification
The bench builds the block with its default parameters: ceilings of 50 and 18, four editable slots, eight display slots and 7-bit limits. With these values every entered value from 00 to 99 can be reached. That covers each ceiling exactly, one above it and one below it, and both cursor wrap-arounds. The bench drives digits in every slot, a confirm with no edit, edits with no confirm, and a full set of inputs while the mode input locks the block.

// File: rtl/limit_entry_pkg.sv
// Package: shared constants for the limit entry controller.
// Assumes: display codes are 4 bits wide; code 10 blanks a display digit.
package limit_entry_pkg;
    localparam int DIGIT_W    = 4;
    localparam logic [DIGIT_W-1:0] BLANK_CODE = 4'd10;
    localparam logic [DIGIT_W-1:0] MAX_DEC    = 4'd9;
endpackage

// File: rtl/limit_cursor.sv
// Module: cursor position over the editable slots, with wrap in both directions.
// Assumes: left/right are single-cycle pulses; enable gates every move.
module limit_cursor #(
    parameter int EDIT_SLOTS = 4,
    parameter int CUR_W      = $clog2(EDIT_SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             go_left,
    input  logic             go_right,
    output logic [CUR_W-1:0] cur
);
    localparam logic [CUR_W-1:0] TOP = CUR_W'(EDIT_SLOTS - 1);

    logic [CUR_W-1:0] cur_q;

    // Move the cursor one slot when exactly one direction is pressed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (en && go_left && !go_right) begin
            cur_q <= (cur_q == TOP) ? '0 : cur_q + 1'b1;
        end else if (en && go_right && !go_left) begin
            cur_q <= (cur_q == '0) ? TOP : cur_q - 1'b1;
        end
    end

    assign cur = cur_q;
endmodule

// File: rtl/limit_digit_buf.sv
// Module: editable digit store plus the display slot map and the blink mask.
// Assumes: only codes 0..9 are written; slots beyond EDIT_SLOTS show blank.
module limit_digit_buf
    import limit_entry_pkg::*;
#(
    parameter int EDIT_SLOTS = 4,
    parameter int DISP_SLOTS = 8,
    parameter int CUR_W      = $clog2(EDIT_SLOTS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [DIGIT_W-1:0]            wr_digit,
    input  logic [CUR_W-1:0]              cur,
    output logic [EDIT_SLOTS*DIGIT_W-1:0] edit_flat,
    output logic [DISP_SLOTS*DIGIT_W-1:0] disp_flat,
    output logic [DISP_SLOTS-1:0]         mask
);
    logic [DIGIT_W-1:0] edit_q [EDIT_SLOTS];

    // Store a decimal key code into the slot under the cursor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < EDIT_SLOTS; i++) edit_q[i] <= '0;
        end else if (wr_en && wr_digit <= MAX_DEC) begin
            edit_q[cur] <= wr_digit;
        end
    end

    // Map editable digits and blanks onto the display slots and set the blink bit.
    for (genvar k = 0; k < DISP_SLOTS; k++) begin : g_slot
        if (k < EDIT_SLOTS) begin : g_edit
            assign disp_flat[k*DIGIT_W +: DIGIT_W] = edit_q[k];
            assign edit_flat[k*DIGIT_W +: DIGIT_W] = edit_q[k];
            assign mask[k] = (cur == CUR_W'(k));
        end else begin : g_blank
            assign disp_flat[k*DIGIT_W +: DIGIT_W] = BLANK_CODE;
            assign mask[k] = 1'b0;
        end
    end
endmodule

// File: rtl/limit_commit.sv
// Module: combines a tens and a ones digit, clamps the value to a ceiling and
// registers it on commit.
// Assumes: the digits are 0..9, so 10*tens+ones fits in VAL_W bits.
module limit_commit
    import limit_entry_pkg::*;
#(
    parameter int CEIL  = 50,
    parameter int VAL_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  logic [DIGIT_W-1:0] tens,
    input  logic [DIGIT_W-1:0] ones,
    output logic [VAL_W-1:0]   value
);
    localparam logic [VAL_W-1:0] CEIL_V = VAL_W'(CEIL);

    logic [VAL_W-1:0] raw;
    logic [VAL_W-1:0] value_q;

    // Form the decimal value from its two digits.
    always_comb begin
        raw = VAL_W'(tens) * VAL_W'(10) + VAL_W'(ones);
    end

    // Latch the clamped value on a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (commit) begin
            value_q <= (raw > CEIL_V) ? CEIL_V : raw;
        end
    end

    assign value = value_q;
endmodule

// File: rtl/limit_entry_ctrl.sv
// Module: top of the keypad limit entry controller. Edits two 2-digit limits
// with a cursor and commits them, each clamped to its ceiling, on confirm.
// Assumes: buttons and key strobe are debounced single-cycle pulses; a low
// set_mode_n enables editing.
module limit_entry_ctrl
    import limit_entry_pkg::*;
#(
    parameter int PILL_CEIL   = 50,
    parameter int BOTTLE_CEIL = 18,
    parameter int EDIT_SLOTS  = 4,
    parameter int DISP_SLOTS  = 8,
    parameter int VAL_W       = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          set_mode_n,
    input  logic                          key_valid,
    input  logic [3:0]                    key_digit,
    input  logic                          btn_left,
    input  logic                          btn_right,
    input  logic                          btn_confirm,
    output logic [VAL_W-1:0]              pill_limit,
    output logic [VAL_W-1:0]              bottle_limit,
    output logic [DISP_SLOTS*DIGIT_W-1:0] disp_digits,
    output logic [DISP_SLOTS-1:0]         blink_mask
);
    localparam int CUR_W = $clog2(EDIT_SLOTS);

    logic                          active;
    logic [CUR_W-1:0]              cur;
    logic [EDIT_SLOTS*DIGIT_W-1:0] edit_flat;

    assign active = !set_mode_n;

    limit_cursor #(.EDIT_SLOTS(EDIT_SLOTS), .CUR_W(CUR_W)) u_cursor (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (active),
        .go_left  (btn_left),
        .go_right (btn_right),
        .cur      (cur)
    );

    limit_digit_buf #(
        .EDIT_SLOTS(EDIT_SLOTS), .DISP_SLOTS(DISP_SLOTS), .CUR_W(CUR_W)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (active && key_valid),
        .wr_digit  (key_digit),
        .cur       (cur),
        .edit_flat (edit_flat),
        .disp_flat (disp_digits),
        .mask      (blink_mask)
    );

    limit_commit #(.CEIL(PILL_CEIL), .VAL_W(VAL_W)) u_pill (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (active && btn_confirm),
        .tens   (edit_flat[1*DIGIT_W +: DIGIT_W]),
        .ones   (edit_flat[0*DIGIT_W +: DIGIT_W]),
        .value  (pill_limit)
    );

    limit_commit #(.CEIL(BOTTLE_CEIL), .VAL_W(VAL_W)) u_bottle (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (active && btn_confirm),
        .tens   (edit_flat[3*DIGIT_W +: DIGIT_W]),
        .ones   (edit_flat[2*DIGIT_W +: DIGIT_W]),
        .value  (bottle_limit)
    );
endmodule

// File: rtl/limit_entry_chk.sv
// Module: property checker bound to the limit entry controller.
// Assumes: default slot counts (cursor rotation written for four editable slots).
module limit_entry_chk #(
    parameter int PILL_CEIL   = 50,
    parameter int BOTTLE_CEIL = 18,
    parameter int DISP_SLOTS  = 8,
    parameter int VAL_W       = 7
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    set_mode_n,
    input logic                    btn_left,
    input logic                    btn_right,
    input logic                    btn_confirm,
    input logic [VAL_W-1:0]        pill_limit,
    input logic [VAL_W-1:0]        bottle_limit,
    input logic [DISP_SLOTS*4-1:0] disp_digits,
    input logic [DISP_SLOTS-1:0]   blink_mask
);
    AST_BLINK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(blink_mask) == 1) && (blink_mask[DISP_SLOTS-1:4] == '0)); // R3

    AST_PILL_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        pill_limit <= VAL_W'(PILL_CEIL)); // R6

    AST_BOTTLE_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        bottle_limit <= VAL_W'(BOTTLE_CEIL)); // R6

    AST_COMMIT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !(btn_confirm && !set_mode_n) |=> $stable(pill_limit) && $stable(bottle_limit)); // R7

    AST_LEFT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_mode_n && btn_left && !btn_right) |=>
        blink_mask == ($past(blink_mask[3]) ? DISP_SLOTS'(1) : ($past(blink_mask) << 1))); // R4

    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        set_mode_n |=> $stable(disp_digits) && $stable(blink_mask)
                       && $stable(pill_limit) && $stable(bottle_limit)); // R8
endmodule

bind limit_entry_ctrl limit_entry_chk #(
    .PILL_CEIL(PILL_CEIL), .BOTTLE_CEIL(BOTTLE_CEIL),
    .DISP_SLOTS(DISP_SLOTS), .VAL_W(VAL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_mode_n   (set_mode_n),
    .btn_left     (btn_left),
    .btn_right    (btn_right),
    .btn_confirm  (btn_confirm),
    .pill_limit   (pill_limit),
    .bottle_limit (bottle_limit),
    .disp_digits  (disp_digits),
    .blink_mask   (blink_mask)
);

// File: tb/tb_limit_entry_ctrl.sv
module tb_limit_entry_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        set_mode_n = 1'b0;
    logic        key_valid = 1'b0;
    logic [3:0]  key_digit = 4'd0;
    logic        btn_left = 1'b0;
    logic        btn_right = 1'b0;
    logic        btn_confirm = 1'b0;
    logic [6:0]  pill_limit;
    logic [6:0]  bottle_limit;
    logic [31:0] disp_digits;
    logic [7:0]  blink_mask;

    int n_checks = 0;
    int n_fails  = 0;

    // Bench model, built from the requirements.
    int exp_cur = 0;
    int exp_d [4] = '{0, 0, 0, 0};
    int exp_pill = 0;
    int exp_bot  = 0;

    limit_entry_ctrl dut (
        .clk(clk), .rst_n(rst_n), .set_mode_n(set_mode_n),
        .key_valid(key_valid), .key_digit(key_digit),
        .btn_left(btn_left), .btn_right(btn_right), .btn_confirm(btn_confirm),
        .pill_limit(pill_limit), .bottle_limit(bottle_limit),
        .disp_digits(disp_digits), .blink_mask(blink_mask)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++; n_fails++;
        $display("FAIL watchdog expired: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_disp();
        return {16'hAAAA, 4'(exp_d[3]), 4'(exp_d[2]), 4'(exp_d[1]), 4'(exp_d[0])};
    endfunction

    task automatic check_all(string req);
        check({req, " display"}, disp_digits, exp_disp());
        check({req, " blink"}, {24'd0, blink_mask}, 32'(8'h01 << exp_cur));
        check({req, " pill"}, {25'd0, pill_limit}, 32'(exp_pill));
        check({req, " bottle"}, {25'd0, bottle_limit}, 32'(exp_bot));
    endtask

    // One input cycle: drive at a falling edge, release at the next, update the model.
    task automatic step(bit l, bit r, bit c, bit kv, int kd);
        @(negedge clk);
        btn_left = l; btn_right = r; btn_confirm = c;
        key_valid = kv; key_digit = 4'(kd);
        @(negedge clk);
        btn_left = 0; btn_right = 0; btn_confirm = 0; key_valid = 0;
        if (!set_mode_n) begin
            if (kv && kd <= 9) exp_d[exp_cur] = kd;
            if (l && !r) exp_cur = (exp_cur == 3) ? 0 : exp_cur + 1;
            if (r && !l) exp_cur = (exp_cur == 0) ? 3 : exp_cur - 1;
            if (c) begin
                exp_pill = exp_d[1] * 10 + exp_d[0];
                if (exp_pill > 50) exp_pill = 50;
                exp_bot = exp_d[3] * 10 + exp_d[2];
                if (exp_bot > 18) exp_bot = 18;
            end
        end
    endtask

    task automatic enter_values(int bt, int bo, int pt, int po);
        while (exp_cur != 3) step(1, 0, 0, 0, 0);
        step(0, 0, 0, 1, bt); step(0, 1, 0, 0, 0);
        step(0, 0, 0, 1, bo); step(0, 1, 0, 0, 0);
        step(0, 0, 0, 1, pt); step(0, 1, 0, 0, 0);
        step(0, 0, 0, 1, po);
    endtask

    task automatic t_reset();
        @(negedge clk); @(negedge clk);
        check_all("R1 reset");
        check("R2 blank upper slots", {16'd0, disp_digits[31:16]}, 32'h0000AAAA);
    endtask

    task automatic t_cursor();
        step(0, 1, 0, 0, 0); check_all("R4 right wrap 0->3");
        check("R4 right wrap mask", {24'd0, blink_mask}, 32'h08);
        step(1, 0, 0, 0, 0); check_all("R4 left wrap 3->0");
        check("R4 left wrap mask", {24'd0, blink_mask}, 32'h01);
        step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0);
        check_all("R3 cursor at slot 2");
        step(1, 1, 0, 0, 0); check_all("R4 both pressed no move");
        step(0, 1, 0, 0, 0); check_all("R4 right 2->1");
    endtask

    task automatic t_keys();
        enter_values(1, 2, 3, 4);
        check("R2 slot layout 12/34", disp_digits, 32'hAAAA_1234);
        step(0, 0, 0, 1, 12); check_all("R5 code 12 ignored");
        step(0, 0, 0, 1, 15); check_all("R5 code 15 ignored");
        step(1, 0, 0, 1, 7);  check_all("R5 write before move");
        check("R5 only slot 0 written", disp_digits, 32'hAAAA_1237);
    endtask

    task automatic t_commit();
        step(0, 0, 1, 0, 0); check_all("R6 commit 12/37");
        check("R6 pill 37", {25'd0, pill_limit}, 32'd37);
        check("R6 edits kept", disp_digits, 32'hAAAA_1237);
        enter_values(9, 9, 9, 9); step(0, 0, 1, 0, 0);
        check_all("R6 clamp 99/99");
        enter_values(1, 8, 5, 0); step(0, 0, 1, 0, 0);
        check_all("R6 exact ceilings 18/50");
        enter_values(1, 9, 5, 1); step(0, 0, 1, 0, 0);
        check_all("R6 one above ceilings 19/51");
        enter_values(1, 7, 4, 9); step(0, 0, 1, 0, 0);
        check_all("R6 below ceilings 17/49");
        enter_values(0, 0, 0, 0); step(0, 0, 1, 0, 0);
        check_all("R6 zero 00/00");
    endtask

    task automatic t_no_commit();
        enter_values(0, 5, 2, 2);
        check_all("R7 edits without confirm");
        check("R7 pill held", {25'd0, pill_limit}, 32'd0);
        step(1, 0, 0, 0, 0); check_all("R7 cursor move no commit");
        step(0, 0, 1, 0, 0); check_all("R7 commit 05/22");
    endtask

    task automatic t_locked();
        @(negedge clk); set_mode_n = 1'b1;
        step(1, 0, 0, 0, 0); check_all("R8 left ignored");
        step(0, 1, 0, 0, 0); check_all("R8 right ignored");
        step(0, 0, 0, 1, 9); check_all("R8 key ignored");
        check("R8 display held", disp_digits, 32'hAAAA_0522);
        @(negedge clk); set_mode_n = 1'b0;
        enter_values(1, 1, 1, 1);
        @(negedge clk); set_mode_n = 1'b1;
        step(0, 0, 1, 0, 0); check_all("R8 confirm ignored");
        check("R8 pill held", {25'd0, pill_limit}, 32'd22);
        @(negedge clk); set_mode_n = 1'b0;
        step(0, 0, 1, 0, 0); check_all("R6 commit after unlock");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cursor();
        t_keys();
        t_commit();
        t_no_commit();
        t_locked();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule